// File: doc/BRIEF.md
# Carrier-Detect Receive Gate

This block stands between a serial receive pin and the frame receiver that follows it. It runs on the receive clock. It uses a carrier-detect input to decide which received bits are forwarded as valid. A bit is forwarded with a one-cycle strobe. When the carrier drops while a frame is still open, the block stops forwarding, emits a halt pulse and sets a sticky carrier-lost flag. The framer reads that flag with the frame status and clears it.

Two configuration bits select how carrier-detect is used. The first picks immediate gating, where carrier-detect acts in the same receive-clock cycle, or sampled gating, where it is registered first and acts one cycle later. The second picks envelope operation, where carrier-detect must cover the whole frame, or pulse operation, where carrier-detect only opens a frame. In pulse operation the frame then runs to its last bit whatever carrier-detect does. The framer marks the last bit of each frame. Once a frame has ended, a new one opens only on a fresh low-to-high carrier-detect transition.

Top module: `cdg_gate`

## Requirements
- R1: While reset is high and in the cycle after reset is released with carrier-detect low, `rx_valid`, `rx_halt`, `rx_data` and `cd_lost` are all 0.
- R2: With `cfg_immediate`=1, a carrier-detect rise seen while no frame is open makes `rx_valid` high in that same cycle. Carrier-detect low in an open envelope frame removes `rx_valid` in that same cycle.
- R3: With `cfg_immediate`=0, every carrier-detect change acts exactly one receive-clock cycle after it appears on the pin. This holds both for opening a frame and for losing the carrier.
- R4: In envelope operation (`cfg_pulse`=0), an effective carrier-detect low while a frame is open and before its last-bit strobe raises `rx_halt` for exactly one cycle. `rx_valid` stays low from that cycle on.
- R5: `cd_lost` becomes 1 in the cycle after an `rx_halt` pulse. It holds until a cycle with `clr_lost`=1 and no new halt. A set and a clear in the same cycle leave it set.
- R6: Carrier-detect that goes low only after the cycle carrying the last-bit strobe (`rx_valid`=1 with `last_bit`=1) produces no halt and leaves `cd_lost` at 0.
- R7: In pulse operation (`cfg_pulse`=1), carrier-detect going low after the frame opens has no effect. `rx_valid` continues up to and including the last-bit strobe, `rx_halt` stays 0 and `cd_lost` stays 0.
- R8: After a frame ends, by its last bit or by a halt, `rx_valid` stays 0 while carrier-detect remains high. A new frame needs carrier-detect to go low and then high again.
- R9: `rx_data` equals `rxd` in cycles where `rx_valid` is 1, and is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial receive data |
| cd | input | 1 | Carrier-detect, active high |
| last_bit | input | 1 | Framer mark: the bit now strobed is the frame's last |
| clr_lost | input | 1 | Clears the carrier-lost flag |
| cfg_immediate | input | 1 | 1: immediate gating, 0: sampled gating |
| cfg_pulse | input | 1 | 1: pulse operation, 0: envelope operation |
| rx_valid | output | 1 | Gated bit strobe |
| rx_data | output | 1 | Gated data bit |
| rx_halt | output | 1 | One-cycle pulse when reception is cut off by carrier loss |
| cd_lost | output | 1 | Sticky carrier-lost error for the current frame |

## Verification
The assertions take three things for granted about the inputs. Both configuration bits stay constant while a frame is open. `last_bit` matters only together with a strobe. In immediate mode, carrier-detect moves only while the receive clock is low. The stimulus respects all three. It drives every input just after the falling clock edge. It changes the configuration only between frames, with carrier-detect low and the gate back at rest. It raises `last_bit` only in the cycle where the bench's own model expects the final strobe. The halt-related properties are therefore checked only under these input conditions.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

    // Receive-side state of the gate
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a fresh carrier rise
        ST_RECV  = 2'd1,   // frame open, bits forwarded
        ST_DRAIN = 2'd2    // frame over, carrier still high
    } gate_state_e;

    typedef struct packed {
        logic immediate;   // 1: carrier acts in the same cycle
        logic pulse;       // 1: carrier only opens the frame
    } gate_cfg_t;

    typedef struct packed {
        logic eff;         // carrier level as the gate sees it
        logic rise;        // low-to-high step of that level
    } cd_view_t;

    // A frame stays open while the carrier is present, or always in pulse operation
    function automatic logic frame_held(gate_cfg_t cfg, cd_view_t v);
        return cfg.pulse | v.eff;
    endfunction

    // State to enter when the last bit has been accepted
    function automatic gate_state_e after_last(cd_view_t v);
        return v.eff ? ST_DRAIN : ST_IDLE;
    endfunction

endpackage

// File: rtl/cdg_sampler.sv
module cdg_sampler
    import cdg_pkg::*;
#(
    parameter int SAMPLE_STAGES = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cd,
    input  logic     immediate,
    output cd_view_t view
);

    localparam int TAP = SAMPLE_STAGES - 1;

    logic chain [0:SAMPLE_STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= cd;
    end

    generate
        for (genvar g = 1; g <= SAMPLE_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    logic lvl, prev;

    always_comb begin
        if (immediate) begin
            lvl  = cd;
            prev = chain[0];
        end else begin
            lvl  = chain[TAP];
            prev = chain[SAMPLE_STAGES];
        end
        view.eff  = lvl;
        view.rise = lvl & ~prev;
    end

endmodule

// File: rtl/cdg_ctrl.sv
module cdg_ctrl
    import cdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_cfg_t cfg,
    input  cd_view_t  view,
    input  logic      last_bit,
    output logic      valid,
    output logic      halt
);

    gate_state_e state, state_nx;
    logic start, keep, done;

    always_comb begin
        start = (state == ST_IDLE) & view.rise;
        keep  = (state == ST_RECV) & frame_held(cfg, view);
        halt  = (state == ST_RECV) & ~frame_held(cfg, view);
        valid = start | keep;
        done  = valid & last_bit;

        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = done ? after_last(view) : ST_RECV;
            end
            ST_RECV: begin
                if (halt)      state_nx = ST_IDLE;
                else if (done) state_nx = after_last(view);
            end
            ST_DRAIN: begin
                if (!view.eff) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/cdg_lost_flag.sv
module cdg_lost_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/cdg_gate.sv
module cdg_gate
    import cdg_pkg::*;
#(
    parameter int SAMPLE_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    input  logic cd,
    input  logic last_bit,
    input  logic clr_lost,
    input  logic cfg_immediate,
    input  logic cfg_pulse,
    output logic rx_valid,
    output logic rx_data,
    output logic rx_halt,
    output logic cd_lost
);

    gate_cfg_t cfg;
    cd_view_t  view;

    assign cfg.immediate = cfg_immediate;
    assign cfg.pulse     = cfg_pulse;

    cdg_sampler #(.SAMPLE_STAGES(SAMPLE_STAGES)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .cd        (cd),
        .immediate (cfg.immediate),
        .view      (view)
    );

    cdg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .view     (view),
        .last_bit (last_bit),
        .valid    (rx_valid),
        .halt     (rx_halt)
    );

    cdg_lost_flag u_lost (
        .clk  (clk),
        .rst  (rst),
        .set  (rx_halt),
        .clr  (clr_lost),
        .flag (cd_lost)
    );

    assign rx_data = rx_valid & rxd;

endmodule

// File: rtl/cdg_gate_chk.sv
module cdg_gate_chk (
    input logic clk,
    input logic rst,
    input logic rxd,
    input logic cfg_pulse,
    input logic clr_lost,
    input logic rx_valid,
    input logic rx_data,
    input logic rx_halt,
    input logic cd_lost
);

    // R4: halt is a single-cycle pulse and never coincides with a strobe
    a_r4_halt_single: assert property (@(posedge clk) disable iff (rst)
        rx_halt |=> !rx_halt);
    a_r4_halt_no_valid: assert property (@(posedge clk) disable iff (rst)
        rx_halt |-> !rx_valid);
    // R4: no strobe in the cycle right after a halt
    a_r4_no_valid_after_halt: assert property (@(posedge clk) disable iff (rst)
        rx_halt |=> !rx_valid);

    // R5: the flag follows a halt and is sticky until cleared
    a_r5_lost_after_halt: assert property (@(posedge clk) disable iff (rst)
        rx_halt |=> cd_lost);
    a_r5_lost_sticky: assert property (@(posedge clk) disable iff (rst)
        (cd_lost && !clr_lost) |=> cd_lost);
    a_r5_lost_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(cd_lost) |-> $past(rx_halt));

    // R7: pulse operation never halts
    a_r7_pulse_no_halt: assert property (@(posedge clk) disable iff (rst)
        cfg_pulse |-> !rx_halt);

    // R9: data is gated by the strobe
    a_r9_data_gated: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> !rx_data);
    a_r9_data_passed: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_data == rxd));

endmodule

bind cdg_gate cdg_gate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rxd       (rxd),
    .cfg_pulse (cfg_pulse),
    .clr_lost  (clr_lost),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_halt   (rx_halt),
    .cd_lost   (cd_lost)
);

// File: tb/sim_cdg_gate.sv
module sim_cdg_gate;

    logic clk = 1'b0;
    logic rst, rxd, cd, last_bit, clr_lost, cfg_immediate, cfg_pulse;
    logic rx_valid, rx_data, rx_halt, cd_lost;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;   // 125 MHz

    cdg_gate u0 (
        .clk(clk), .rst(rst), .rxd(rxd), .cd(cd), .last_bit(last_bit),
        .clr_lost(clr_lost), .cfg_immediate(cfg_immediate), .cfg_pulse(cfg_pulse),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_halt(rx_halt), .cd_lost(cd_lost)
    );

    task automatic check(string req, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive a cycle's inputs just after the falling edge, then observe
    task automatic drive(logic c, logic d, logic lb, logic clr);
        @(negedge clk);
        cd = c; rxd = d; last_bit = lb; clr_lost = clr;
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1; cd = 0; rxd = 0; last_bit = 0; clr_lost = 0;
        cfg_immediate = 0; cfg_pulse = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "rx_valid in reset", rx_valid, 1'b0);
        check("R1", "rx_halt in reset", rx_halt, 1'b0);
        check("R1", "cd_lost in reset", cd_lost, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        check("R1", "rx_valid after reset", rx_valid, 1'b0);
        check("R1", "rx_data after reset", rx_data, 1'b0);
        check("R1", "cd_lost after reset", cd_lost, 1'b0);
    endtask

    // One frame of n bits; carrier driven high from cycle 0 and low from cycle drop
    task automatic t_frame(logic imm, logic pls, int n, int drop);
        int  lat  = imm ? 0 : 1;            // R2 / R3 latency
        int  last = lat + n - 1;            // cycle of the final strobe
        bit  loss = !pls && (drop <= n - 1); // R4 / R6 / R7
        int  hcyc = drop + lat;
        string rq = pls ? "R7" : (loss ? "R4" : "R6");
        cfg_immediate = imm; cfg_pulse = pls;
        for (int t = 0; t <= last + 3; t++) begin
            logic c  = (t < drop);
            logic d  = logic'(t[0] ^ t[1]);
            logic ev = (t >= lat) && (t <= last) && (pls || !loss || t < hcyc);
            logic eh = loss && (t == hcyc);
            logic lb = ev && (t == last);
            drive(c, d, lb, 1'b0);
            check(imm ? "R2" : "R3", "rx_valid", rx_valid, ev);
            if (t > last) check("R8", "no strobe after frame end", rx_valid, 1'b0);
            check(rq, "rx_halt", rx_halt, eh);
            check("R5", "cd_lost", cd_lost, logic'(loss && t > hcyc));
            check("R9", "rx_data", rx_data, ev ? d : 1'b0);
        end
        // carrier back low, gate returns to rest; flag must persist
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0);
            check("R8", "rx_valid idle", rx_valid, 1'b0);
        end
        check("R5", "cd_lost sticky", cd_lost, logic'(loss));
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "cd_lost cleared", cd_lost, 1'b0);
    endtask

    // R5: a halt and a clear in the same cycle leave the flag set
    task automatic t_set_beats_clear();
        cfg_immediate = 1; cfg_pulse = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        check("R5", "halt with clear", rx_halt, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "set wins over clear", cd_lost, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "cleared afterwards", cd_lost, 1'b0);
    endtask

    initial begin
        #(8 * 20000);
        miscompares++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        for (int m = 0; m < 4; m++) begin
            logic imm = logic'(m[0]);
            logic pls = logic'(m[1]);
            t_frame(imm, pls, 6, 2);   // early loss of carrier
            t_frame(imm, pls, 6, 5);   // carrier drops on the last bit
            t_frame(imm, pls, 6, 6);   // carrier drops just after the last bit
            t_frame(imm, pls, 6, 9);   // carrier outlasts the frame (R8)
        end
        t_frame(1'b1, 1'b0, 1, 4);      // single-bit frame
        t_set_beats_clear();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule